// File: doc/BRIEF.md
# Byte FIFO Pair with Receive End-of-Message Detection

This block buffers bytes in both directions between a serial controller and a host register port. Host writes to the data location fill a transmit FIFO, and the serial controller drains it with a pop strobe. The serial controller pushes received bytes into a receive FIFO, and host reads of the same data location drain it. A status register reports empty, half and full for each FIFO. A control register resets each FIFO on its own and enables two aids that mark the end of a message.

Byte-oriented protocols have no hardware frame end. The first aid counts idle character-times: when the receive FIFO holds data and no byte has arrived for a programmed number of character-times, a sticky timeout flag is set. The second aid compares every accepted received byte with a programmed match byte and sets a sticky pattern flag on equality. Either flag drives the interrupt output. The host clears a flag by writing 1 to its bit. Two DMA request outputs tell a DMA engine that the transmit FIFO has room or that the receive FIFO has data.

Register map (4-bit offset): 0x0 data (write: push transmit, read: pop receive), 0x9 status (read-only), 0xA control, 0xB match byte, 0xC timeout length in character-times, 0xD clock ticks per character-time, 0xE interrupt flags. All other offsets read 0.

Top module: `serial_byte_buffer`

## Requirements
- R1: After reset, status (0x9) reads 0x11, control reads 0x00, interrupt flags read 0x00, `irq` is 0, `tx_dreq` is 1 and `rx_dreq` is 0.
- R2: Each FIFO returns bytes in push order. Status bit 0 shows transmit empty, bit 1 transmit half (occupancy at least DEPTH/2) and bit 2 transmit full. Bits 4, 5 and 6 show the same three flags for receive. Bits 3 and 7 read 0.
- R3: A push into a full FIFO is dropped and the FIFO contents do not change.
- R4: A host read of offset 0x0 with the receive FIFO empty returns 0 and leaves the pointers unchanged. A pop of an empty transmit FIFO has no effect, and `tx_byte` reads 0 while that FIFO is empty.
- R5: Control bit 0 clears only the transmit FIFO, and bit 4 clears only the receive FIFO. Each reset bit reads 1 for one cycle after the write and then reads 0. Bit 5 (timeout enable) and bit 6 (pattern enable) are stored. Bits 1–3 and 7 read 0.
- R6: With timeout enabled, N=reg 0xC (nonzero) and T=reg 0xD (nonzero), flag bit 0 of 0xE sets exactly N*T clocks after the last accepted receive push. Each accepted push restarts the count. Nothing counts while the receive FIFO is empty or the timeout is disabled. Once fired, the flag is not raised again until a further push.
- R7: With pattern detection enabled, an accepted receive byte equal to reg 0xB sets flag bit 1 of 0xE. With it disabled, a matching byte leaves the flag at 0.
- R8: `irq` is the OR of the two flags. Writing 1 to a bit of 0xE clears that flag, and writing 0 leaves it unchanged.
- R9: `tx_dreq` is high exactly while the transmit FIFO is not full. `rx_dreq` is high exactly while the receive FIFO is not empty.
- R10: `tx_byte` shows the oldest transmit byte, and `tx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive at 0x0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| tx_pop | input | 1 | Serial side takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte |
| rx_push | input | 1 | Serial side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count shows up in the status flags and DMA requests in the cycle after the push or pop that caused it, and a pointer fault shows up as bytes in the wrong order on the next read. A timeout counter that is off by one moves the flag by one clock, so the bench samples exactly one clock before and at N*T for every N and T in a small sweep. A comparator or enable fault shows up as a missing or spurious flag bit on the first matching byte.

// File: rtl/serial_byte_buffer.sv
module serial_byte_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_byte,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  localparam logic [3:0] A_DATA  = 4'h0;
  localparam logic [3:0] A_STAT  = 4'h9;
  localparam logic [3:0] A_CTRL  = 4'hA;
  localparam logic [3:0] A_MATCH = 4'hB;
  localparam logic [3:0] A_NCHR  = 4'hC;
  localparam logic [3:0] A_TPC   = 4'hD;
  localparam logic [3:0] A_FLAG  = 4'hE;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;

  logic tx_rst_q, rx_rst_q, tmo_en, pat_en;
  logic [DW-1:0] match_b, n_chars, tpc;
  logic tmo_flag, pat_flag;
  logic [DW-1:0] tick, chr;

  logic tx_empty, tx_full, tx_half, rx_empty, rx_full, rx_half;
  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == (AW+1)'(DEPTH));
  assign tx_half  = (tx_cnt >= (AW+1)'(HALF));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == (AW+1)'(DEPTH));
  assign rx_half  = (rx_cnt >= (AW+1)'(HALF));

  logic wr_data, wr_ctrl, wr_flag;
  assign wr_data = reg_we && reg_addr == A_DATA;
  assign wr_ctrl = reg_we && reg_addr == A_CTRL;
  assign wr_flag = reg_we && reg_addr == A_FLAG;

  logic tx_wr_ok, tx_rd_ok, rx_wr_ok, rx_rd_ok;
  assign tx_wr_ok = wr_data && !tx_full;
  assign tx_rd_ok = tx_pop && !tx_empty;
  assign rx_wr_ok = rx_push && !rx_full;
  assign rx_rd_ok = reg_re && reg_addr == A_DATA && !rx_empty;

  // transmit FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst_q) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_wr_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_rd_ok) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (AW+1)'(tx_wr_ok) - (AW+1)'(tx_rd_ok);
    end
  end

  always_ff @(posedge clk)
    if (tx_wr_ok && !tx_rst_q) tx_mem[tx_wp] <= reg_wdata;

  // receive FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst_q) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_wr_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_rd_ok) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (AW+1)'(rx_wr_ok) - (AW+1)'(rx_rd_ok);
    end
  end

  always_ff @(posedge clk)
    if (rx_wr_ok && !rx_rst_q) rx_mem[rx_wp] <= rx_byte;

  // configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rst_q <= 1'b0; rx_rst_q <= 1'b0;
      tmo_en <= 1'b0; pat_en <= 1'b0;
      match_b <= '0; n_chars <= '0; tpc <= DW'(1);
    end else begin
      tx_rst_q <= wr_ctrl && reg_wdata[0];
      rx_rst_q <= wr_ctrl && reg_wdata[4];
      if (wr_ctrl) begin
        tmo_en <= reg_wdata[5];
        pat_en <= reg_wdata[6];
      end
      if (reg_we && reg_addr == A_MATCH) match_b <= reg_wdata;
      if (reg_we && reg_addr == A_NCHR)  n_chars <= reg_wdata;
      if (reg_we && reg_addr == A_TPC)   tpc     <= reg_wdata;
    end
  end

  // idle timeout in character-times
  logic tick_wrap, tmo_hold, tmo_fire, pat_hit;
  assign tick_wrap = (tick == tpc - DW'(1));
  assign tmo_hold  = !tmo_en || rx_empty || rx_rst_q;
  assign tmo_fire  = !tmo_hold && !rx_wr_ok && n_chars != '0 &&
                     tick_wrap && chr == n_chars - DW'(1);
  assign pat_hit   = pat_en && rx_wr_ok && !rx_rst_q && rx_byte == match_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0; chr <= '0;
    end else if (tmo_hold || rx_wr_ok) begin
      tick <= '0; chr <= '0;
    end else if (chr != n_chars) begin
      if (tick_wrap) begin
        tick <= '0;
        chr  <= chr + DW'(1);
      end else begin
        tick <= tick + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0; pat_flag <= 1'b0;
    end else begin
      if (tmo_fire) tmo_flag <= 1'b1;
      else if (wr_flag && reg_wdata[0]) tmo_flag <= 1'b0;
      if (pat_hit) pat_flag <= 1'b1;
      else if (wr_flag && reg_wdata[1]) pat_flag <= 1'b0;
    end
  end

  // host read mux
  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_empty ? '0 : rx_mem[rx_rp];
      A_STAT:  reg_rdata = {1'b0, rx_full, rx_half, rx_empty,
                            1'b0, tx_full, tx_half, tx_empty};
      A_CTRL:  reg_rdata = {1'b0, pat_en, tmo_en, rx_rst_q, 3'b000, tx_rst_q};
      A_MATCH: reg_rdata = match_b;
      A_NCHR:  reg_rdata = n_chars;
      A_TPC:   reg_rdata = tpc;
      A_FLAG:  reg_rdata = {6'b0, pat_flag, tmo_flag};
      default: reg_rdata = '0;
    endcase
  end

  assign tx_byte = tx_empty ? '0 : tx_mem[tx_rp];
  assign tx_dreq = !tx_full;
  assign rx_dreq = !rx_empty;
  assign irq     = tmo_flag || pat_flag;
endmodule

// File: rtl/serial_byte_buffer_chk.sv
module serial_byte_buffer_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rx_push,
  input logic                     rx_pop,
  input logic [$clog2(DEPTH):0]   rx_cnt,
  input logic                     rx_rst_q,
  input logic                     rx_empty,
  input logic                     tx_rst_q,
  input logic                     tx_empty,
  input logic                     reg_re,
  input logic [3:0]               reg_addr,
  input logic [7:0]               reg_rdata,
  input logic                     tmo_flag,
  input logic                     pat_flag,
  input logic                     pat_en
);
  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == ($clog2(DEPTH)+1)'(DEPTH) && rx_push && !rx_pop && !rx_rst_q) |=> $stable(rx_cnt));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == 4'h0 && rx_empty) |-> reg_rdata == 8'h00);

  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_q |=> tx_empty);

  // R6
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(!rx_empty));

  // R7
  pat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pat_flag) |-> $past(rx_push && pat_en));
endmodule

bind serial_byte_buffer serial_byte_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_rd_ok),
  .rx_cnt(rx_cnt), .rx_rst_q(rx_rst_q), .rx_empty(rx_empty),
  .tx_rst_q(tx_rst_q), .tx_empty(tx_empty), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tmo_flag(tmo_flag),
  .pat_flag(pat_flag), .pat_en(pat_en)
);

// File: tb/tb_serial_byte_buffer.sv
module tb_serial_byte_buffer;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_we = 0, reg_re = 0, tx_pop = 0, rx_push = 0;
  logic [7:0] reg_wdata = '0, rx_byte = '0;
  logic [7:0] reg_rdata, tx_byte;
  logic tx_dreq, rx_dreq, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  serial_byte_buffer #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_re = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(logic [7:0] b);
    rx_byte = b; rx_push = 1;
    @(negedge clk);
    rx_push = 0;
  endtask

  function automatic logic [7:0] stat(int t, int r);
    return {1'b0, r == DEPTH, r >= DEPTH/2, r == 0, 1'b0, t == DEPTH, t >= DEPTH/2, t == 0};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(4'h9, v); check("R1 status", v, 8'h11);
    peek(4'hA, v); check("R1 control", v, 8'h00);
    peek(4'hE, v); check("R1 flags", v, 8'h00);
    check("R1 pins", {irq, tx_dreq, rx_dreq}, 3'b010);

    // R2 R3 R9 transmit fill sweep
    for (int k = 1; k <= DEPTH + 2; k++) begin
      int c;
      wr(4'h0, 8'(k));
      c = (k > DEPTH) ? DEPTH : k;
      peek(4'h9, v); check("R2 R3 tx status", v, stat(c, 0));
      check("R9 tx_dreq", tx_dreq, c != DEPTH);
    end
    // R10 drain in order
    for (int k = 0; k < DEPTH; k++) begin
      check("R10 tx_byte", tx_byte, 8'(k + 1));
      tx_pop = 1; @(negedge clk); tx_pop = 0;
      peek(4'h9, v); check("R2 tx drain status", v, stat(DEPTH - 1 - k, 0));
    end
    // R4 pop when empty
    check("R4 tx_byte empty", tx_byte, 8'h00);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    peek(4'h9, v); check("R4 tx pop empty", v, 8'h11);
    wr(4'h0, 8'hC3);
    check("R4 tx after empty pop", tx_byte, 8'hC3);
    tx_pop = 1; @(negedge clk); tx_pop = 0;

    // R2 R3 R9 receive fill sweep
    for (int k = 1; k <= DEPTH + 2; k++) begin
      int c;
      push(8'h40 + 8'(k));
      c = (k > DEPTH) ? DEPTH : k;
      peek(4'h9, v); check("R2 R3 rx status", v, stat(0, c));
      check("R9 rx_dreq", rx_dreq, 1'b1);
    end
    for (int k = 1; k <= DEPTH; k++) begin
      rd(4'h0, v); check("R2 R3 rx order", v, 8'h40 + 8'(k));
    end
    check("R9 rx_dreq empty", rx_dreq, 1'b0);
    // R4 read when empty
    rd(4'h0, v); check("R4 rx empty read", v, 8'h00);
    peek(4'h9, v); check("R4 rx still empty", v, 8'h11);
    push(8'h77);
    rd(4'h0, v); check("R4 rx pointers intact", v, 8'h77);

    // R5 per-FIFO reset and readback
    for (int k = 0; k < 3; k++) wr(4'h0, 8'(k));
    push(8'h01); push(8'h02);
    wr(4'hA, 8'h01);
    peek(4'hA, v); check("R5 tx reset bit", v, 8'h01);
    @(negedge clk);
    peek(4'hA, v); check("R5 self clear", v, 8'h00);
    peek(4'h9, v); check("R5 tx only", v, stat(0, 2));
    wr(4'hA, 8'hFF);
    peek(4'hA, v); check("R5 write ff", v, 8'h71);
    @(negedge clk);
    peek(4'hA, v); check("R5 stored enables", v, 8'h60);
    peek(4'h9, v); check("R5 rx cleared", v, 8'h11);
    wr(4'hA, 8'h00);

    // R7 R8 pattern sweep
    wr(4'hB, 8'h5A);
    wr(4'hA, 8'h40);
    for (int b = 8'h50; b <= 8'h5F; b++) begin
      push(8'(b));
      peek(4'hE, v); check("R7 pattern flag", v, (b >= 8'h5A) ? 8'h02 : 8'h00);
      check("R8 irq", irq, b >= 8'h5A);
    end
    wr(4'hE, 8'h01);
    peek(4'hE, v); check("R8 write 0 keeps", v, 8'h02);
    wr(4'hE, 8'h02);
    peek(4'hE, v); check("R8 w1c", v, 8'h00);
    check("R8 irq cleared", irq, 1'b0);
    wr(4'hA, 8'h10); wr(4'hA, 8'h00); @(negedge clk);
    push(8'h5A);
    peek(4'hE, v); check("R7 disabled", v, 8'h00);
    wr(4'hA, 8'h10); @(negedge clk);

    // R6 timeout empty FIFO does nothing
    wr(4'hC, 8'd1); wr(4'hD, 8'd1); wr(4'hA, 8'h20);
    repeat (20) @(negedge clk);
    check("R6 empty no timeout", irq, 1'b0);

    // R6 timeout sweep
    for (int n = 1; n <= 3; n++) begin
      for (int t = 1; t <= 3; t++) begin
        wr(4'hA, 8'h30); @(negedge clk);
        wr(4'hC, 8'(n)); wr(4'hD, 8'(t));
        push(8'hA5);
        repeat (n * t - 1) @(negedge clk);
        check("R6 before timeout", irq, 1'b0);
        @(negedge clk);
        peek(4'hE, v); check("R6 at timeout", v, 8'h01);
        wr(4'hE, 8'h01);
        repeat (3 * n * t) @(negedge clk);
        check("R6 no refire", irq, 1'b0);
      end
    end

    // R6 restart on push
    wr(4'hA, 8'h30); @(negedge clk);
    wr(4'hC, 8'd3); wr(4'hD, 8'd2);
    push(8'h11);
    repeat (5) @(negedge clk);
    push(8'h22);
    repeat (5) @(negedge clk);
    check("R6 restarted", irq, 1'b0);
    @(negedge clk);
    check("R6 after restart", irq, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule